// File: doc/BRIEF.md
# Predicated Microsequencer with Call and Return

This block is the fetch and control-flow unit of a small coprocessor that runs 24-bit instructions. It holds the program counter and presents it as the fetch address. Instruction memory sits outside the block and returns the word at that address in the same cycle. The block decodes only the control opcodes: unconditional jump, branch on a predicate being set or clear, call, return and sleep. Every other opcode belongs to the execution side, and for those the block simply steps the counter by one.

A branch tests one of four predicate slots, selected by an instruction field. Slots 0 to 2 are read from an external predicate file through a read port. Slot 3 has no storage behind it and returns the live interrupt line instead. The same branch instructions can therefore test either a computed flag or a pending interrupt.

The target of a jump or call is 8 bits wide and is assembled from two separate instruction fields. Calls save their return address on a four-entry return stack. A call into a full stack, or a return from an empty one, raises a sticky error flag. Sleep parks the program counter until a wake pulse arrives.

Top module: `pms_top`

## Requirements
- R1: While reset is held, and for two clock edges after it is released, the fetch address is 0 and both the sleeping and stack-error outputs are low.
- R2: Any opcode (instruction bits 5:0) other than 0x26, 0x28, 0x2a, 0x2b, 0x2c, 0x2e and 0x2f moves the fetch address to fetch address + 1 on the next cycle, wrapping from 0xFF to 0x00.
- R3: Opcodes 0x28 and 0x2c load the fetch address with the target. The target's bits 5:0 are instruction bits 13:8, and its bits 7:6 are instruction bits 18:17.
- R4: Opcode 0x2b jumps to the target when the selected predicate is 1 and otherwise steps by one. Opcode 0x2a jumps when the selected predicate is 0 and otherwise steps by one.
- R5: `pred_idx_o` carries instruction bits 15:14. When it equals 3, the predicate value is `irq_i`, and `pred_val_i` has no effect.
- R6: Opcode 0x2e pushes fetch address + 1 onto the return stack and jumps to the target. Opcode 0x2f jumps to the most recently pushed address that has not yet been popped, and removes it.
- R7: The return stack holds 4 entries. A call while it is full does not push and steps by one. A return while it is empty steps by one. Both cases raise `stack_err_o` on the next cycle.
- R8: Once `stack_err_o` is high, it stays high until reset.
- R9: Opcode 0x26 raises `sleeping_o` on the next cycle and holds the fetch address. While sleeping, a high `wake_i` clears `sleeping_o` and moves to fetch address + 1 on the next cycle. `wake_i` has no effect when the block is not sleeping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| instr_i | input | 24 | Instruction word stored at `fetch_addr_o` |
| pred_idx_o | output | 2 | Predicate slot selected by the current instruction |
| pred_val_i | input | 1 | Predicate file value for `pred_idx_o` (used for slots 0 to 2) |
| irq_i | input | 1 | Live interrupt line, read as predicate slot 3 |
| wake_i | input | 1 | Wake request that ends a sleep |
| fetch_addr_o | output | 8 | Program counter and next fetch address |
| sleeping_o | output | 1 | Block is parked in sleep |
| stack_err_o | output | 1 | Sticky return-stack overflow or underflow |

## Verification
The bench targets the following corner cases, each chosen because a plausible bug would show up there:
- Calls nested past four levels. A design with an off-by-one stack pointer would overwrite the oldest return address or jump into a call it should have refused.
- A return from an empty stack. A wrong design would jump to a stale or zero address instead of stepping.
- Branches on slot 3. Here the predicate file is deliberately driven with the inverse of the interrupt line, so a design that read storage for slot 3 would branch the wrong way.
- Targets with the upper field set, and sleeps held for many cycles before a wake. These expose a design that dropped bits 18:17, or that drifted, resumed at the wrong address, or reacted to `wake_i` outside a sleep.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int INSN_W   = 24;
  localparam int TGT_W    = 8;
  localparam int PSEL_W   = 2;

  localparam int OPC_LSB  = 0;
  localparam int OPC_W    = 6;
  localparam int TLO_LSB  = 8;
  localparam int TLO_W    = 6;
  localparam int THI_LSB  = 17;
  localparam int THI_W    = 2;
  localparam int PSEL_LSB = 14;

  localparam logic [OPC_W-1:0] OPC_SLEEP = 6'h26;
  localparam logic [OPC_W-1:0] OPC_JMP_A = 6'h28;
  localparam logic [OPC_W-1:0] OPC_BR_F  = 6'h2a;
  localparam logic [OPC_W-1:0] OPC_BR_T  = 6'h2b;
  localparam logic [OPC_W-1:0] OPC_JMP_B = 6'h2c;
  localparam logic [OPC_W-1:0] OPC_CALL  = 6'h2e;
  localparam logic [OPC_W-1:0] OPC_RET   = 6'h2f;

  typedef enum logic [2:0] {
    CF_STEP,
    CF_JUMP,
    CF_BR_CLR,
    CF_BR_SET,
    CF_CALL,
    CF_RET,
    CF_SLEEP
  } cf_kind_e;
endpackage

// File: rtl/pms_decode.sv
module pms_decode
  import pms_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output cf_kind_e          kind_o,
  output logic [TGT_W-1:0]  tgt_o,
  output logic [PSEL_W-1:0] psel_o
);
  logic [OPC_W-1:0] opc;

  assign opc    = insn_i[OPC_LSB +: OPC_W];
  assign tgt_o  = {insn_i[THI_LSB +: THI_W], insn_i[TLO_LSB +: TLO_W]};
  assign psel_o = insn_i[PSEL_LSB +: PSEL_W];

  always_comb begin
    unique case (opc)
      OPC_JMP_A, OPC_JMP_B: kind_o = CF_JUMP;
      OPC_BR_F:             kind_o = CF_BR_CLR;
      OPC_BR_T:             kind_o = CF_BR_SET;
      OPC_CALL:             kind_o = CF_CALL;
      OPC_RET:              kind_o = CF_RET;
      OPC_SLEEP:            kind_o = CF_SLEEP;
      default:              kind_o = CF_STEP;
    endcase
  end
endmodule

// File: rtl/pms_pred_sel.sv
module pms_pred_sel #(
  parameter int SLOTS    = 4,
  parameter int IRQ_SLOT = 3,
  localparam int SEL_W   = $clog2(SLOTS)
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             file_val_i,
  input  logic             irq_i,
  output logic             pred_o
);
  logic is_irq_slot;

  assign is_irq_slot = (sel_i == SEL_W'(IRQ_SLOT));
  assign pred_o      = is_irq_slot ? irq_i : file_val_i;
endmodule

// File: rtl/pms_retstack.sv
module pms_retstack #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] top_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [SP_W-1:0]   sp_q, sp_d;
  logic              sp_en;
  logic              push_ok, pop_ok;
  logic              err_q, err_d;

  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  always_comb begin
    sp_d  = sp_q;
    sp_en = push_ok || pop_ok;
    if (push_ok)     sp_d = sp_q + SP_W'(1);
    else if (pop_ok) sp_d = sp_q - SP_W'(1);
  end

  always_comb begin
    err_d = err_q || (push_i && full_o) || (pop_i && empty_o);
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp_q == SP_W'(i + 1)) top_o = slot_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = push_ok && (sp_q == SP_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_q[g] <= '0;
      else if (wr_en) slot_q[g] <= push_data_i;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/pms_top.sv
module pms_top
  import pms_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int STACK_DEPTH = 4,
  parameter int PRED_SLOTS  = 4,
  parameter int IRQ_SLOT    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INSN_W-1:0] instr_i,
  output logic [PSEL_W-1:0] pred_idx_o,
  input  logic              pred_val_i,
  input  logic              irq_i,
  input  logic              wake_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              sleeping_o,
  output logic              stack_err_o
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  cf_kind_e          kind;
  logic [TGT_W-1:0]  tgt_raw;
  logic [ADDR_W-1:0] tgt;
  logic [PSEL_W-1:0] psel;
  logic              pred;

  pms_decode u_decode (
    .insn_i (instr_i),
    .kind_o (kind),
    .tgt_o  (tgt_raw),
    .psel_o (psel)
  );

  assign tgt = ADDR_W'(tgt_raw);

  pms_pred_sel #(
    .SLOTS    (PRED_SLOTS),
    .IRQ_SLOT (IRQ_SLOT)
  ) u_pred_sel (
    .sel_i      (psel),
    .file_val_i (pred_val_i),
    .irq_i      (irq_i),
    .pred_o     (pred)
  );

  logic [ADDR_W-1:0] pc_q, pc_d, pc_inc, ret_addr;
  logic              pc_en;
  logic              sleep_q, sleep_d;
  logic              push, pop, stk_full, stk_empty, stk_err;

  pms_retstack #(
    .DEPTH  (STACK_DEPTH),
    .DATA_W (ADDR_W)
  ) u_retstack (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (pc_inc),
    .top_o       (ret_addr),
    .full_o      (stk_full),
    .empty_o     (stk_empty),
    .err_o       (stk_err)
  );

  assign pc_inc = pc_q + ADDR_W'(1);
  assign pc_en  = !sleep_q || wake_i;

  always_comb begin
    pc_d    = pc_q;
    sleep_d = sleep_q;
    push    = 1'b0;
    pop     = 1'b0;
    if (sleep_q) begin
      if (wake_i) begin
        pc_d    = pc_inc;
        sleep_d = 1'b0;
      end
    end else begin
      unique case (kind)
        CF_JUMP:   pc_d = tgt;
        CF_BR_CLR: pc_d = pred ? pc_inc : tgt;
        CF_BR_SET: pc_d = pred ? tgt : pc_inc;
        CF_CALL: begin
          push = 1'b1;
          pc_d = stk_full ? pc_inc : tgt;
        end
        CF_RET: begin
          pop  = 1'b1;
          pc_d = stk_empty ? pc_inc : ret_addr;
        end
        CF_SLEEP:  sleep_d = 1'b1;
        default:   pc_d = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pc_q <= '0;
    else if (pc_en)  pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sleep_q <= 1'b0;
    else             sleep_q <= sleep_d;
  end

  assign pred_idx_o   = psel;
  assign fetch_addr_o = pc_q;
  assign sleeping_o   = sleep_q;
  assign stack_err_o  = stk_err;
endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_ni,
  input logic [23:0]       instr_i,
  input logic [1:0]        pred_idx_o,
  input logic              pred_val_i,
  input logic              irq_i,
  input logic              wake_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              sleeping_o,
  input logic              stack_err_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [5:0]        op;
  logic [ADDR_W-1:0] tgt_w;
  logic              pv;
  logic              run;

  assign op    = instr_i[5:0];
  assign tgt_w = ADDR_W'({instr_i[18:17], instr_i[13:8]});
  assign pv    = (pred_idx_o == 2'd3) ? irq_i : pred_val_i;
  assign run   = !sleeping_o;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    run && (op < 6'h20) |=> fetch_addr_o == $past(fetch_addr_o) + ONE);

  p_jump_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    run && (op == 6'h28 || op == 6'h2c) |=> fetch_addr_o == $past(tgt_w));

  p_brset_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    run && op == 6'h2b && pv |=> fetch_addr_o == $past(tgt_w));

  p_brclr_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    run && op == 6'h2a && pv |=> fetch_addr_o == $past(fetch_addr_o) + ONE);

  p_irq_slot_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    run && op == 6'h2b && pred_idx_o == 2'd3 && !irq_i
      |=> fetch_addr_o == $past(fetch_addr_o) + ONE);

  p_call_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    run && op == 6'h2e && !stack_err_o |=> stack_err_o || fetch_addr_o == $past(tgt_w));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    stack_err_o |=> stack_err_o);

  p_sleep_enter_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    run && op == 6'h26 |=> sleeping_o && $stable(fetch_addr_o));

  p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    sleeping_o && !wake_i |=> sleeping_o && $stable(fetch_addr_o));

  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    sleeping_o && wake_i |=> !sleeping_o && fetch_addr_o == $past(fetch_addr_o) + ONE);
endmodule

bind pms_top pms_checker #(.ADDR_W(ADDR_W)) u_pms_checker (
  .clk          (clk),
  .rst_ni       (rst_sync_n),
  .instr_i      (instr_i),
  .pred_idx_o   (pred_idx_o),
  .pred_val_i   (pred_val_i),
  .irq_i        (irq_i),
  .wake_i       (wake_i),
  .fetch_addr_o (fetch_addr_o),
  .sleeping_o   (sleeping_o),
  .stack_err_o  (stack_err_o)
);

// File: tb/test_pms_top.sv
module test_pms_top;
  logic        clk;
  logic        rst_n;
  logic [23:0] instr_i;
  logic [1:0]  pred_idx_o;
  logic        pred_val_i;
  logic        irq_i;
  logic        wake_i;
  logic [7:0]  fetch_addr_o;
  logic        sleeping_o;
  logic        stack_err_o;

  logic [23:0] imem [256];
  logic        pfile [4];

  int checks;
  int failures;
  bit finished;

  pms_top i_pms_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_i      (instr_i),
    .pred_idx_o   (pred_idx_o),
    .pred_val_i   (pred_val_i),
    .irq_i        (irq_i),
    .wake_i       (wake_i),
    .fetch_addr_o (fetch_addr_o),
    .sleeping_o   (sleeping_o),
    .stack_err_o  (stack_err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign instr_i = imem[fetch_addr_o];
  // slot 3 storage deliberately disagrees with irq_i (R5)
  assign pred_val_i = (pred_idx_o == 2'd3) ? ~irq_i : pfile[pred_idx_o];

  // reference model state
  logic [7:0] m_pc;
  logic       m_sleep;
  logic       m_err;
  logic [7:0] m_stk [4];
  int         m_sp;
  int         m_hold;
  string      m_tag;

  function automatic logic [23:0] enc(logic [5:0] op, logic [7:0] tg, logic [1:0] pi);
    return {5'd0, tg[7:6], 1'b0, pi, tg[5:0], 2'd0, op};
  endfunction

  function automatic bit is_ctrl(logic [5:0] op);
    return op == 6'h26 || op == 6'h28 || op == 6'h2a || op == 6'h2b ||
           op == 6'h2c || op == 6'h2e || op == 6'h2f;
  endfunction

  function automatic logic [23:0] rand_word();
    logic [5:0] op;
    int r;
    r = $urandom % 16;
    case (r)
      6, 7: op = ($urandom % 2) ? 6'h28 : 6'h2c;
      8:    op = 6'h2a;
      9:    op = 6'h2b;
      10, 11: op = 6'h2e;
      12, 13: op = 6'h2f;
      14:   op = 6'h26;
      default: begin
        op = 6'($urandom);
        while (is_ctrl(op)) op = 6'($urandom);
      end
    endcase
    return {6'($urandom) & 6'h3f, op} ^ {18'($urandom), 6'd0};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pc = 8'd0; m_sleep = 1'b0; m_err = 1'b0; m_sp = 0; m_hold = 2; m_tag = "R1";
    for (int i = 0; i < 4; i++) m_stk[i] = 8'd0;
  endtask

  task automatic model_step();
    logic [23:0] w;
    logic [5:0]  op;
    logic [7:0]  tg;
    logic        pv;
    w  = imem[m_pc];
    op = w[5:0];
    tg = {w[18:17], w[13:8]};
    pv = (w[15:14] == 2'd3) ? irq_i : pfile[w[15:14]];
    if (m_hold > 0) begin
      m_hold--;
      m_tag = "R1";
    end else if (m_sleep) begin
      m_tag = "R9";
      if (wake_i) begin m_pc = m_pc + 8'd1; m_sleep = 1'b0; end
    end else begin
      case (op)
        6'h28, 6'h2c: begin m_pc = tg; m_tag = "R3"; end
        6'h2b: begin m_pc = pv ? tg : m_pc + 8'd1; m_tag = (w[15:14] == 3) ? "R5" : "R4"; end
        6'h2a: begin m_pc = pv ? m_pc + 8'd1 : tg; m_tag = (w[15:14] == 3) ? "R5" : "R4"; end
        6'h2e: begin
          if (m_sp == 4) begin m_err = 1'b1; m_pc = m_pc + 8'd1; m_tag = "R7"; end
          else begin m_stk[m_sp] = m_pc + 8'd1; m_sp++; m_pc = tg; m_tag = "R6"; end
        end
        6'h2f: begin
          if (m_sp == 0) begin m_err = 1'b1; m_pc = m_pc + 8'd1; m_tag = "R7"; end
          else begin m_sp--; m_pc = m_stk[m_sp]; m_tag = "R6"; end
        end
        6'h26: begin m_sleep = 1'b1; m_tag = "R9"; end
        default: begin m_pc = m_pc + 8'd1; m_tag = "R2"; end
      endcase
    end
  endtask

  // one cycle: check outputs, drive inputs, advance model
  task automatic cycle(int wake_pct, int irq_pct);
    @(negedge clk);
    check({m_tag, " fetch_addr"}, 32'(fetch_addr_o), 32'(m_pc));
    check("R9 sleeping", 32'(sleeping_o), 32'(m_sleep));
    check("R8 stack_err", 32'(stack_err_o), 32'(m_err));
    check("R5 pred_idx", 32'(pred_idx_o), 32'(imem[m_pc][15:14]));
    wake_i = (($urandom % 100) < wake_pct);
    irq_i  = (($urandom % 100) < irq_pct);
    for (int i = 0; i < 4; i++) pfile[i] = 1'($urandom);
    model_step();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check("R1 reset pc", 32'(fetch_addr_o), 32'd0);
    check("R1 reset sleep", 32'(sleeping_o), 32'd0);
    check("R1 reset err", 32'(stack_err_o), 32'd0);
    rst_n = 1'b1;
    model_step();
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    checks = 0; failures = 0; finished = 0;
    rst_n = 1'b0; wake_i = 1'b0; irq_i = 1'b0;
    for (int i = 0; i < 4; i++) pfile[i] = 1'b0;
    for (int i = 0; i < 256; i++) imem[i] = enc(6'h00, 8'd0, 2'd0);
    model_reset();
    repeat (3) @(posedge clk);

    // directed: return from empty stack (R7), then err stays (R8)
    imem[0] = enc(6'h2f, 8'd0, 2'd0);
    do_reset();
    repeat (12) cycle(0, 0);

    // directed: nested calls overflow the 4-deep stack (R6, R7)
    for (int i = 0; i < 5; i++) imem[i] = enc(6'h2e, 8'(i + 1), 2'd0);
    imem[5] = enc(6'h2f, 8'd0, 2'd0);
    do_reset();
    repeat (40) cycle(0, 0);

    // directed: high target field, irq slot branches (R3, R5)
    for (int i = 0; i < 256; i++) imem[i] = enc(6'h01, 8'd0, 2'd0);
    imem[0] = enc(6'h28, 8'hc5, 2'd0);
    imem[8'hc5] = enc(6'h2b, 8'h40, 2'd3);
    imem[8'hc6] = enc(6'h2a, 8'h80, 2'd3);
    imem[8'h40] = enc(6'h2c, 8'hc6, 2'd0);
    imem[8'hff] = enc(6'h02, 8'd0, 2'd0);
    do_reset();
    repeat (60) cycle(0, 50);

    // directed: long sleep, wake only after many cycles (R9)
    imem[0] = enc(6'h26, 8'd0, 2'd0);
    do_reset();
    repeat (20) cycle(0, 0);
    repeat (4) cycle(100, 0);
    repeat (280) cycle(0, 0);

    // constrained random programs
    for (int ph = 0; ph < 20; ph++) begin
      for (int i = 0; i < 256; i++) imem[i] = rand_word();
      do_reset();
      repeat (2000) cycle(15 + ph, 30);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule